// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block owns the status byte of a serial flash memory and rules on every request that would modify the memory. Program and erase requests arrive with a target byte address. Status-write requests arrive with a new status byte. The block answers each request with a one-cycle grant or deny pulse. A status write that is granted becomes a self-timed cycle, and busy is raised for its whole length.

Three things decide each answer. The first is a write-enable latch, set and cleared by decoded commands. The second is a pair of block-protect bits, which make the top quarter, the top half or the whole array read-only. The third is a hardware write-protect input, which has force only while the protect-enable bit of the status byte is set.

A status write is first held pending while chip select stays low. The internal cycle starts on the cycle in which chip select is seen high. Before that point, a protect assertion cancels the write. Once the cycle has started, the protect input can no longer reach it.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, busy is low, and no grant or deny pulse is raised.
- R2: A write-enable command sets the latch, which reads back as status bit 1. A write-disable command clears it. When both commands arrive in the same cycle, the clear wins.
- R3: A program/erase request is answered one cycle later by exactly one pulse, either mod_grant or mod_deny. It is granted only when all four conditions hold: the latch is set, no status cycle is busy, no status write is pending, and the address is not protected.
- R4: The block-protect field is status bits 3:2, and it is checked against the sector index, which is address bits 16:15 in the four-sector build. The codes are: 00 protects nothing, 01 protects sector 3, 10 protects sectors 2 and 3, and 11 protects all sectors.
- R5: In the two-sector build (16-bit address), any non-zero block-protect code protects the whole array.
- R6: A status-write request is denied one cycle later (sr_deny) in any of these cases: the latch is clear, the block is busy, a write is already pending, chip select is high, or the protect input is low while the protect-enable bit (status bit 7) is 1.
- R7: While the protect-enable bit is 0, the protect input has no effect, so a status write with the protect input low is granted.
- R8: If the protect input is low while a write is pending and the protect-enable bit is 1, the write is cancelled. In that case sr_deny pulses, no cycle starts, and status bits 7 and 3:2 stay unchanged.
- R9: A pending write starts its cycle on the first clock at which chip select is high. sr_grant pulses one cycle later, and busy is high for exactly SR_CYCLES cycles. Only bit 7 and bits 3:2 of the request data are then written. A protect assertion during busy does not alter the outcome.
- R10: The latch is cleared by completion of a status write, by the mod_done input, and by every deny.
- R11: The status byte layout is bit 7 protect-enable, bits 3:2 block-protect, bit 1 write-enable latch, bit 0 busy, with bits 6:4 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Hardware write-protect, active low |
| wren_cmd | input | 1 | Decoded write-enable command pulse |
| wrdi_cmd | input | 1 | Decoded write-disable command pulse |
| sr_wr_req | input | 1 | Status-write request pulse |
| sr_wr_data | input | 8 | New status byte carried by the request |
| mod_req | input | 1 | Program or erase request pulse |
| mod_addr | input | ADDR_W | Target byte address of the program/erase |
| mod_done | input | 1 | Program/erase engine completion pulse |
| mod_grant | output | 1 | Program/erase granted |
| mod_deny | output | 1 | Program/erase denied |
| sr_grant | output | 1 | Status write cycle started |
| sr_deny | output | 1 | Status write denied or cancelled |
| status_o | output | 8 | Current status byte |
| busy_o | output | 1 | Self-timed status write in progress |

## Verification
A wrong latch state appears at status bit 1 on the next cycle. It then shows as a wrong grant/deny pulse on the very next request. A wrong protect decode or a wrong lock decision surfaces one cycle after the request, as the opposite pulse on the same port pair. A fault in the pending/started boundary shows in one of two ways: an sr_deny pulse where sr_grant belonged, or a busy window whose length differs from SR_CYCLES. The committed bits become visible at the clock that ends busy, so a mis-masked data bit is caught at that cycle.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;

  localparam int unsigned SECTOR_LOG2 = 15;
  localparam int unsigned ST_WPEN  = 7;
  localparam int unsigned ST_BP_HI = 3;
  localparam int unsigned ST_BP_LO = 2;
  localparam int unsigned ST_WEL   = 1;
  localparam int unsigned ST_BUSY  = 0;

  typedef enum logic {SR_IDLE = 1'b0, SR_PEND = 1'b1} sr_state_e;

  // Protection decision for the multi-sector variant.
  function automatic logic bp_covers(input logic [1:0] bp,
                                     input int unsigned sec,
                                     input int unsigned nsec);
    logic hit;
    case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (sec >= nsec - nsec / 4);
      2'b10:   hit = (sec >= nsec - nsec / 2);
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  function automatic logic [7:0] pack_status(input logic wpen,
                                             input logic [1:0] bp,
                                             input logic wel,
                                             input logic busy);
    logic [7:0] s;
    s = 8'h00;
    s[ST_WPEN] = wpen;
    s[ST_BP_HI:ST_BP_LO] = bp;
    s[ST_WEL] = wel;
    s[ST_BUSY] = busy;
    return s;
  endfunction

endpackage

// File: rtl/wpsc_protect_map.sv
module wpsc_protect_map #(
  parameter int unsigned SECTOR_COUNT = 4,
  parameter int unsigned ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bp_i,
  output logic              prot_o
);
  import wpsc_pkg::*;

  localparam int unsigned SEC_W = ADDR_W - SECTOR_LOG2;

  logic [SEC_W-1:0] sector;
  assign sector = addr_i[ADDR_W-1:SECTOR_LOG2];

  generate
    if (SECTOR_COUNT >= 4) begin : g_graded
      always_comb prot_o = bp_covers(bp_i, int'(unsigned'(sector)), SECTOR_COUNT);
    end else begin : g_whole
      always_comb prot_o = (bp_i != 2'b00);
    end
  endgenerate

endmodule

// File: rtl/wpsc_sr_timer.sv
module wpsc_sr_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == ONE);

  AST_TIMER_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o) else $error("timer did not start"); // R9
  AST_TIMER_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o) else $error("timer restarted while busy"); // R9

endmodule

// File: rtl/wpsc_wel.sv
module wpsc_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_o <= 1'b0;
    else if (clr_i)  wel_o <= 1'b0;
    else if (set_i)  wel_o <= 1'b1;
  end

  AST_WEL_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !wel_o) else $error("latch survived a clear"); // R2
  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> wel_o) else $error("latch not set"); // R2

endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
  parameter int unsigned SECTOR_COUNT = 4,
  parameter int unsigned SR_CYCLES = 16,
  localparam int unsigned ADDR_W = $clog2(SECTOR_COUNT) + 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              wren_cmd,
  input  logic              wrdi_cmd,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  input  logic              mod_req,
  input  logic [ADDR_W-1:0] mod_addr,
  input  logic              mod_done,
  output logic              mod_grant,
  output logic              mod_deny,
  output logic              sr_grant,
  output logic              sr_deny,
  output logic [7:0]        status_o,
  output logic              busy_o
);
  import wpsc_pkg::*;

  sr_state_e  state_q;
  logic       wpen_q;
  logic [1:0] bp_q;
  logic [7:0] data_q;
  logic       wel;
  logic       busy;
  logic       sec_prot;

  // Named internal events
  logic wp_lock, mod_ok, mod_accept_ev, mod_reject_ev;
  logic sr_accept_ev, sr_reject_ev, cancel_ev, start_ev, commit_ev, wel_clr;

  wpsc_protect_map #(.SECTOR_COUNT(SECTOR_COUNT), .ADDR_W(ADDR_W)) u_map (
    .addr_i(mod_addr), .bp_i(bp_q), .prot_o(sec_prot));

  wpsc_sr_timer #(.CYCLES(SR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_ev), .busy_o(busy), .done_o(commit_ev));

  wpsc_wel u_wel (
    .clk(clk), .rst_n(rst_n), .set_i(wren_cmd), .clr_i(wel_clr), .wel_o(wel));

  always_comb begin
    wp_lock       = !wp_n && wpen_q;
    mod_ok        = wel && !busy && (state_q == SR_IDLE) && !sec_prot;
    mod_accept_ev = mod_req && mod_ok;
    mod_reject_ev = mod_req && !mod_ok;
    sr_accept_ev  = sr_wr_req && !cs_n && (state_q == SR_IDLE) && !busy && wel && !wp_lock;
    sr_reject_ev  = sr_wr_req && !sr_accept_ev;
    cancel_ev     = (state_q == SR_PEND) && wp_lock;
    start_ev      = (state_q == SR_PEND) && !wp_lock && cs_n;
    wel_clr       = wrdi_cmd || mod_reject_ev || sr_reject_ev || cancel_ev
                    || commit_ev || mod_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SR_IDLE;
      data_q  <= 8'h00;
    end else if (sr_accept_ev) begin
      state_q <= SR_PEND;
      data_q  <= sr_wr_data;
    end else if (cancel_ev || start_ev) begin
      state_q <= SR_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
    end else if (commit_ev) begin
      wpen_q <= data_q[ST_WPEN];
      bp_q   <= data_q[ST_BP_HI:ST_BP_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_grant <= 1'b0;
      mod_deny  <= 1'b0;
      sr_grant  <= 1'b0;
      sr_deny   <= 1'b0;
    end else begin
      mod_grant <= mod_accept_ev;
      mod_deny  <= mod_reject_ev;
      sr_grant  <= start_ev;
      sr_deny   <= sr_reject_ev || cancel_ev;
    end
  end

  assign status_o = pack_status(wpen_q, bp_q, wel, busy);
  assign busy_o   = busy;

  AST_MOD_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req && !status_o[ST_WEL] |=> mod_deny) else $error("grant without latch"); // R3
  AST_BUSY_BLOCKS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req && busy_o |=> mod_deny) else $error("grant while busy"); // R3
  AST_PROT_BLOCKS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req && sec_prot |=> mod_deny) else $error("protected sector granted"); // R4
  AST_WP_LOCKS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_req && !wp_n && status_o[ST_WPEN] |=> sr_deny) else $error("locked status write passed"); // R6
  AST_CANCEL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SR_PEND) && !wp_n && status_o[ST_WPEN] |=> sr_deny && !busy_o) else $error("cancel failed"); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(status_o[7:2])) else $error("status changed without commit"); // R9
  AST_COMMIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> !status_o[ST_WEL]) else $error("latch kept after commit"); // R10
  AST_DENY_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    mod_deny |-> !status_o[ST_WEL]) else $error("latch kept after deny"); // R10
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_grant && mod_deny)) else $error("both answers raised"); // R3

endmodule

// File: tb/wp_status_ctrl_tb.sv
module wp_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SC = 8;
  localparam logic [3:0] C_MG = 4'b1000, C_MD = 4'b0100, C_SG = 4'b0010, C_SD = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1, wren_cmd = 1'b0, wrdi_cmd = 1'b0;
  logic sr_wr_req = 1'b0, mod_req = 1'b0, mod_done = 1'b0;
  logic [7:0] sr_wr_data = 8'h00;
  logic [16:0] mod_addr = '0;
  logic mod_grant, mod_deny, sr_grant, sr_deny, busy_o;
  logic [7:0] status_o;
  logic s_mg, s_md, s_sg, s_sd, s_busy;
  logic [7:0] s_status;

  int checks = 0, errors = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_status_ctrl #(.SECTOR_COUNT(4), .SR_CYCLES(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wren_cmd(wren_cmd),
    .wrdi_cmd(wrdi_cmd), .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
    .mod_req(mod_req), .mod_addr(mod_addr), .mod_done(mod_done),
    .mod_grant(mod_grant), .mod_deny(mod_deny), .sr_grant(sr_grant),
    .sr_deny(sr_deny), .status_o(status_o), .busy_o(busy_o));

  wp_status_ctrl #(.SECTOR_COUNT(2), .SR_CYCLES(SC)) small_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wren_cmd(wren_cmd),
    .wrdi_cmd(wrdi_cmd), .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
    .mod_req(mod_req), .mod_addr(mod_addr[15:0]), .mod_done(mod_done),
    .mod_grant(s_mg), .mod_deny(s_md), .sr_grant(s_sg), .sr_deny(s_sd),
    .status_o(s_status), .busy_o(s_busy));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_pulse(input logic [3:0] code, input string req);
    exp_q.push_back(code);
    tag_q.push_back(req);
  endtask

  // Monitor: compares every answer pulse against the scoreboard queue.
  always @(negedge clk) begin
    logic [3:0] obs;
    obs = {mod_grant, mod_deny, sr_grant, sr_deny};
    if (rst_n && obs != 4'b0000) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected pulse: actual %b expected none", obs);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs !== e) begin
          errors++;
          $display("FAIL %s: actual %b expected %b", t, obs, e);
        end
      end
    end
  end

  task automatic cmd(input bit en, input bit dis);
    @(posedge clk); #1;
    wren_cmd = en; wrdi_cmd = dis;
    @(posedge clk); #1;
    wren_cmd = 1'b0; wrdi_cmd = 1'b0;
  endtask

  task automatic done_pulse();
    @(posedge clk); #1; mod_done = 1'b1;
    @(posedge clk); #1; mod_done = 1'b0;
  endtask

  task automatic mod(input logic [16:0] a, input logic [3:0] e, input string req);
    @(posedge clk); #1;
    mod_req = 1'b1; mod_addr = a;
    expect_pulse(e, req);
    @(posedge clk); #1;
    mod_req = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] d, input bit ok, input bit cancel,
                          input bit wp_busy, input bit mod_busy, input string req);
    @(posedge clk); #1;
    cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = d;
    if (!ok) expect_pulse(C_SD, req);
    @(posedge clk); #1;
    sr_wr_req = 1'b0;
    if (!ok) begin
      cs_n = 1'b1;
    end else if (cancel) begin
      wp_n = 1'b0;
      expect_pulse(C_SD, "R8 cancel");
      @(posedge clk); #1;
      wp_n = 1'b1; cs_n = 1'b1;
      chk("R8 no busy after cancel", {7'd0, busy_o}, 8'h00);
    end else begin
      cs_n = 1'b1;
      expect_pulse(C_SG, req);
      @(posedge clk); #1;
      chk("R9 busy at start", {7'd0, busy_o}, 8'h01);
      if (wp_busy) wp_n = 1'b0;
      if (mod_busy) begin
        mod_req = 1'b1; mod_addr = '0;
        expect_pulse(C_MD, "R3 busy deny");
        @(posedge clk); #1;
        mod_req = 1'b0;
        repeat (SC - 2) @(posedge clk);
      end else begin
        repeat (SC - 1) @(posedge clk);
      end
      #1;
      chk("R9 busy last cycle", {7'd0, busy_o}, 8'h01);
      @(posedge clk); #1;
      chk("R9 busy drops", {7'd0, busy_o}, 8'h00);
      if (wp_busy) wp_n = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset busy", {7'd0, busy_o}, 8'h00);
    chk("R1 no pulses", {4'd0, mod_grant, mod_deny, sr_grant, sr_deny}, 8'h00);

    mod(17'h00000, C_MD, "R3 no latch");
    cmd(1, 0); chk("R2 R11 latch set", status_o, 8'h02);
    cmd(0, 1); chk("R2 latch cleared", status_o, 8'h00);
    cmd(1, 1); chk("R2 clear wins", status_o, 8'h00);

    cmd(1, 0);
    @(posedge clk); #1; mod_req = 1'b1; mod_addr = 17'h00000; expect_pulse(C_MG, "R3 grant");
    @(posedge clk); #1; mod_req = 1'b0;
    chk("R5 small grant bp=00", {7'd0, s_mg}, 8'h01);
    chk("R3 latch kept on grant", status_o, 8'h02);
    done_pulse(); chk("R10 done clears latch", status_o, 8'h00);

    sr_write(8'hF7, 0, 0, 0, 0, "R6 no latch");
    cmd(1, 0);
    sr_write(8'hF7, 1, 0, 1, 0, "R9 write");
    chk("R9 R10 masked commit", status_o, 8'h84);

    cmd(1, 0); mod(17'h18000, C_MD, "R4 sector3 bp=01");
    chk("R10 deny clears latch", status_o, 8'h84);
    cmd(1, 0);
    @(posedge clk); #1; mod_req = 1'b1; mod_addr = 17'h10000; expect_pulse(C_MG, "R4 sector2 bp=01");
    @(posedge clk); #1; mod_req = 1'b0;
    chk("R5 small whole array", {7'd0, s_md}, 8'h01);
    done_pulse();

    wp_n = 1'b0; cmd(1, 0);
    sr_write(8'h88, 0, 0, 0, 0, "R6 wp lock");
    chk("R6 status unchanged", status_o, 8'h84);
    wp_n = 1'b1;

    cmd(1, 0);
    sr_write(8'h88, 1, 1, 0, 0, "R8");
    chk("R8 status unchanged", status_o, 8'h84);

    cmd(1, 0);
    sr_write(8'h88, 1, 0, 1, 1, "R9 wp in busy");
    chk("R9 commit despite wp", status_o, 8'h88);
    cmd(1, 0); mod(17'h10000, C_MD, "R4 sector2 bp=10");
    cmd(1, 0); mod(17'h08000, C_MG, "R4 sector1 bp=10");
    done_pulse();

    cmd(1, 0);
    sr_write(8'h0C, 1, 0, 0, 0, "R9 bp=11");
    chk("R11 bp=11 layout", status_o, 8'h0C);
    cmd(1, 0); mod(17'h00000, C_MD, "R4 sector0 bp=11");

    wp_n = 1'b0; cmd(1, 0);
    sr_write(8'h80, 1, 0, 0, 0, "R7 wpen0 ignores wp");
    chk("R7 status", status_o, 8'h80);
    cmd(1, 0);
    sr_write(8'h00, 0, 0, 0, 0, "R6 wpen1 wp low");
    chk("R6 still locked", status_o, 8'h80);
    wp_n = 1'b1;

    repeat (3) @(posedge clk); #1;
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule